// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block takes 32-bit instruction words aimed at a floating-point unit with its own loads and stores. For each word it produces a registered bundle: an operation number, an operand-class number, the register indices the class uses, the sign-extended displacement, the condition-field numbers, the immediate, the mask and the bit number. It also reports whether the word is illegal, whether the addressing form writes the effective address back to its base register, and whether a base index of zero stands for a zero base.

Decode has two levels. The primary opcode picks a family. Indexed memory forms and double-precision control use a 10-bit extended opcode. Arithmetic uses a 5-bit one. Under the double-precision primary, bit 5 chooses which of the two tables applies. Legality depends on the opcodes and also on whether the base index is zero. Address arithmetic, register reads and the arithmetic itself are left to the pipeline that consumes the bundle.

Top module: `fpu_insn_decoder`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. While `valid_i` is low, every other output keeps its last value. Reset clears all outputs to zero.
- R2: Primary opcode `insn_i[31:26]` values 48 to 55 are displacement memory forms (`fmt_o`=1). The operation is 1 load-single for 48/49, 2 load-double for 50/51, 3 store-single for 52/53 and 4 store-double for 54/55. Every legal word gives a non-zero `op_o` and `fmt_o`.
- R3: Primary 31 decodes the 10-bit extended opcode in `insn_i[10:1]` as an indexed form (`fmt_o`=2). The values are 535/567 load-single, 599/631 load-double, 663/695 store-single, 727/759 store-double, and 983 store-integer-word (`op_o`=5). The second value of each pair is the update form. Any other value is illegal.
- R4: Primary 59 decodes `insn_i[5:1]` with `sp_o`=1. The values are 18 divide (6), 20 subtract (7), 21 add (8), 22 square root (9), 24 reciprocal estimate (10), 25 multiply (11), 26 reciprocal-sqrt estimate (12), 28 multiply-subtract (13), 29 multiply-add (14), 30 negated multiply-subtract (15) and 31 negated multiply-add (16). Any other value, including 23, is illegal. `sp_o` is 0 for every other primary.
- R5: Primary 63 with `insn_i[5]`=1 uses the same 5-bit table with `sp_o`=0, plus 23 select (17). An unmatched value is illegal; it is never looked up in the 10-bit table.
- R6: Primary 63 with `insn_i[5]`=0 decodes `insn_i[10:1]` as follows:
  - 0 unordered compare (18), 32 ordered compare (22)
  - 12 round to single (19), 14 convert to integer (20), 15 convert to integer toward zero (21)
  - 38 set status bit (23), 70 clear status bit (26)
  - 40 negate (24), 72 move (27), 136 negative absolute (29), 264 absolute (30)
  - 64 move status field (25), 134 set status field from immediate (28)
  - 583 read status (31), 711 write status under mask (32)
  - any other value is illegal
- R7: A primary opcode outside {31, 48..55, 59, 63} is illegal.
- R8: Base-index legality depends on `insn_i[20:16]` being zero:
  - a displacement update form with base index 0 is illegal;
  - an indexed non-update form with base index 0 is illegal, except store-integer-word;
  - `zero_base_o` is 1 for a legal memory form whose base index is 0.
- R9: Register fields are target `insn_i[25:21]`, A `insn_i[20:16]`, B `insn_i[15:11]` and C `insn_i[10:6]`. Each class fills only the fields it uses and drives the rest to zero:

  | Class | `fmt_o` | Fields used |
  |---|---|---|
  | displacement | 1 | target, A |
  | indexed | 2 | target, A, B |
  | divide/add/subtract | 3 | target, A, B |
  | multiply | 4 | target, A, C |
  | fused and select | 5 | target, A, B, C |
  | unary | 6 | target, B |
  | compare | 7 | A, B |
  | write-under-mask | 11 | B |
  | read-status | 12 | target |

- R10: In the displacement class, `disp_o` is `insn_i[15:0]` sign-extended to XLEN. It is zero in every other class.
- R11: Control fields depend on the class; each field is zero where its class does not use it:
  - compare (7), move-field (8) and immediate (10): `crf_dst_o` = `insn_i[25:23]`;
  - move-field: `crf_src_o` = `insn_i[20:18]`;
  - immediate: `imm_o` = `insn_i[15:12]`;
  - write-under-mask (11): `mask_o` = `insn_i[24:17]`;
  - set/clear-bit (9): `bit_o` = `insn_i[25:21]`.
- R12: `update_o` is 1 exactly for the update memory forms: primaries 49, 51, 53, 55 and extended opcodes 567, 631, 695, 759.
- R13: `record_o` carries `insn_i[0]` for legal words.
- R14: An illegal word still produces `valid_o`, with `illegal_o`=1 and every other output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word strobe |
| insn_i | input | 32 | Instruction word |
| valid_o | output | 1 | Decoded bundle valid |
| illegal_o | output | 1 | Word is illegal |
| op_o | output | 6 | Operation number |
| fmt_o | output | 4 | Operand class number |
| sp_o | output | 1 | Single-precision arithmetic |
| update_o | output | 1 | Form writes the address back to the base register |
| zero_base_o | output | 1 | Base index 0 stands for a zero base |
| record_o | output | 1 | Record flag |
| rt_o | output | 5 | Target register |
| ra_o | output | 5 | Register A / base |
| rb_o | output | 5 | Register B / index |
| rc_o | output | 5 | Register C |
| disp_o | output | XLEN | Sign-extended displacement |
| crf_dst_o | output | 3 | Destination condition field |
| crf_src_o | output | 3 | Source status field |
| imm_o | output | 4 | Field immediate |
| mask_o | output | 8 | Field write mask |
| bit_o | output | 5 | Status bit number |

## Verification
Every decoded result, including the illegal flag and the zeroed fields, appears one clock edge after the strobe. An idle cycle shows `valid_o` low in the following cycle, with the fields unchanged.

The bench drives each word half a period before a rising edge. At the next falling edge it compares every output with a behavioural model computed from the word of the previous cycle, so each result is sampled in the single cycle where it is due. Directed words cover the zero-base legality corners, the table boundaries and the field positions. Biased random words cover the rest of the opcode space.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 6;
  localparam int FMT_W  = 4;
  localparam int REG_W  = 5;
  localparam int CRF_W  = 3;
  localparam int IMM_W  = 4;
  localparam int MASK_W = 8;
  localparam int DISP_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 6'd0,
    OP_LDS   = 6'd1,  OP_LDD   = 6'd2,  OP_STS   = 6'd3,  OP_STD   = 6'd4,
    OP_STIW  = 6'd5,
    OP_DIV   = 6'd6,  OP_SUB   = 6'd7,  OP_ADD   = 6'd8,  OP_SQRT  = 6'd9,
    OP_RE    = 6'd10, OP_MUL   = 6'd11, OP_RSQE  = 6'd12, OP_MSUB  = 6'd13,
    OP_MADD  = 6'd14, OP_NMSUB = 6'd15, OP_NMADD = 6'd16, OP_SEL   = 6'd17,
    OP_CMPU  = 6'd18, OP_RSP   = 6'd19, OP_CVTI  = 6'd20, OP_CVTIZ = 6'd21,
    OP_CMPO  = 6'd22, OP_SETB  = 6'd23, OP_NEG   = 6'd24, OP_MVFLD = 6'd25,
    OP_CLRB  = 6'd26, OP_MOVE  = 6'd27, OP_SETFI = 6'd28, OP_NABS  = 6'd29,
    OP_ABS   = 6'd30, OP_RDST  = 6'd31, OP_WRST  = 6'd32
  } op_e;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONE = 4'd0,  FMT_DISP = 4'd1,  FMT_IDX  = 4'd2,  FMT_AB   = 4'd3,
    FMT_AC   = 4'd4,  FMT_ABC  = 4'd5,  FMT_B    = 4'd6,  FMT_CMP  = 4'd7,
    FMT_CRF  = 4'd8,  FMT_BIT  = 4'd9,  FMT_IMM  = 4'd10, FMT_MASK = 4'd11,
    FMT_T    = 4'd12
  } fmt_e;

  // 5-bit arithmetic table; select exists only in the double-precision family
  function automatic op_e arith5(input logic [4:0] xo, input logic dbl);
    case (xo)
      5'd18:   return OP_DIV;
      5'd20:   return OP_SUB;
      5'd21:   return OP_ADD;
      5'd22:   return OP_SQRT;
      5'd23:   return dbl ? OP_SEL : OP_NONE;
      5'd24:   return OP_RE;
      5'd25:   return OP_MUL;
      5'd26:   return OP_RSQE;
      5'd28:   return OP_MSUB;
      5'd29:   return OP_MADD;
      5'd30:   return OP_NMSUB;
      5'd31:   return OP_NMADD;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic fmt_e arith_fmt(input op_e op);
    case (op)
      OP_DIV, OP_SUB, OP_ADD:                        return FMT_AB;
      OP_MUL:                                        return FMT_AC;
      OP_SQRT, OP_RE, OP_RSQE:                       return FMT_B;
      OP_MSUB, OP_MADD, OP_NMSUB, OP_NMADD, OP_SEL:  return FMT_ABC;
      default:                                       return FMT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fpdec_classify.sv
module fpdec_classify
  import fpdec_pkg::*;
(
  input  logic [5:0]       prim_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [9:0]       xo_i,
  output op_e              op_o,
  output fmt_e             fmt_o,
  output logic             sp_o,
  output logic             upd_o,
  output logic             legal_o
);
  logic is_mem;
  logic base_zero;

  assign is_mem    = (prim_i[5:3] == 3'b110);
  assign base_zero = (base_i == '0);

  always_comb begin
    op_o  = OP_NONE;
    fmt_o = FMT_NONE;
    sp_o  = 1'b0;
    upd_o = 1'b0;
    if (is_mem) begin
      fmt_o = FMT_DISP;
      upd_o = prim_i[0];
      case (prim_i[2:1])
        2'd0:    op_o = OP_LDS;
        2'd1:    op_o = OP_LDD;
        2'd2:    op_o = OP_STS;
        default: op_o = OP_STD;
      endcase
    end else begin
      case (prim_i)
        6'd31: begin
          fmt_o = FMT_IDX;
          case (xo_i)
            10'd535: op_o = OP_LDS;
            10'd567: begin op_o = OP_LDS; upd_o = 1'b1; end
            10'd599: op_o = OP_LDD;
            10'd631: begin op_o = OP_LDD; upd_o = 1'b1; end
            10'd663: op_o = OP_STS;
            10'd695: begin op_o = OP_STS; upd_o = 1'b1; end
            10'd727: op_o = OP_STD;
            10'd759: begin op_o = OP_STD; upd_o = 1'b1; end
            10'd983: op_o = OP_STIW;
            default: op_o = OP_NONE;
          endcase
        end
        6'd59: begin
          op_o  = arith5(xo_i[4:0], 1'b0);
          fmt_o = arith_fmt(op_o);
          sp_o  = 1'b1;
        end
        6'd63: begin
          if (xo_i[4]) begin
            op_o  = arith5(xo_i[4:0], 1'b1);
            fmt_o = arith_fmt(op_o);
          end else begin
            case (xo_i)
              10'd0:   begin op_o = OP_CMPU;  fmt_o = FMT_CMP;  end
              10'd12:  begin op_o = OP_RSP;   fmt_o = FMT_B;    end
              10'd14:  begin op_o = OP_CVTI;  fmt_o = FMT_B;    end
              10'd15:  begin op_o = OP_CVTIZ; fmt_o = FMT_B;    end
              10'd32:  begin op_o = OP_CMPO;  fmt_o = FMT_CMP;  end
              10'd38:  begin op_o = OP_SETB;  fmt_o = FMT_BIT;  end
              10'd40:  begin op_o = OP_NEG;   fmt_o = FMT_B;    end
              10'd64:  begin op_o = OP_MVFLD; fmt_o = FMT_CRF;  end
              10'd70:  begin op_o = OP_CLRB;  fmt_o = FMT_BIT;  end
              10'd72:  begin op_o = OP_MOVE;  fmt_o = FMT_B;    end
              10'd134: begin op_o = OP_SETFI; fmt_o = FMT_IMM;  end
              10'd136: begin op_o = OP_NABS;  fmt_o = FMT_B;    end
              10'd264: begin op_o = OP_ABS;   fmt_o = FMT_B;    end
              10'd583: begin op_o = OP_RDST;  fmt_o = FMT_T;    end
              10'd711: begin op_o = OP_WRST;  fmt_o = FMT_MASK; end
              default: begin op_o = OP_NONE;  fmt_o = FMT_NONE; end
            endcase
          end
        end
        default: op_o = OP_NONE;
      endcase
    end
  end

  // zero base: forbidden for displacement update and indexed non-update (bar store-integer-word)
  always_comb begin
    legal_o = (op_o != OP_NONE);
    if (fmt_o == FMT_DISP && upd_o && base_zero)
      legal_o = 1'b0;
    if (fmt_o == FMT_IDX && !upd_o && base_zero && op_o != OP_STIW)
      legal_o = 1'b0;
  end
endmodule

// File: rtl/fpdec_fields.sv
module fpdec_fields
  import fpdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [25:0]       body_i,
  input  fmt_e              fmt_i,
  output logic [REG_W-1:0]  rt_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [REG_W-1:0]  rc_o,
  output logic [XLEN-1:0]   disp_o,
  output logic [CRF_W-1:0]  crf_dst_o,
  output logic [CRF_W-1:0]  crf_src_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [REG_W-1:0]  bit_o
);
  localparam int EXT_W = (XLEN > DISP_W) ? XLEN - DISP_W : 1;

  logic use_t, use_a, use_b, use_c;
  logic [XLEN-1:0] disp_ext;

  assign use_t = fmt_i inside {FMT_DISP, FMT_IDX, FMT_AB, FMT_AC, FMT_ABC, FMT_B, FMT_T};
  assign use_a = fmt_i inside {FMT_DISP, FMT_IDX, FMT_AB, FMT_AC, FMT_ABC, FMT_CMP};
  assign use_b = fmt_i inside {FMT_IDX, FMT_AB, FMT_ABC, FMT_B, FMT_CMP, FMT_MASK};
  assign use_c = fmt_i inside {FMT_AC, FMT_ABC};

  generate
    if (XLEN > DISP_W) begin : g_sext
      assign disp_ext = {{EXT_W{body_i[DISP_W-1]}}, body_i[DISP_W-1:0]};
    end else begin : g_trunc
      assign disp_ext = body_i[XLEN-1:0];
    end
  endgenerate

  assign rt_o      = use_t ? body_i[25:21] : '0;
  assign ra_o      = use_a ? body_i[20:16] : '0;
  assign rb_o      = use_b ? body_i[15:11] : '0;
  assign rc_o      = use_c ? body_i[10:6]  : '0;
  assign disp_o    = (fmt_i == FMT_DISP) ? disp_ext : '0;
  assign crf_dst_o = (fmt_i inside {FMT_CMP, FMT_CRF, FMT_IMM}) ? body_i[25:23] : '0;
  assign crf_src_o = (fmt_i == FMT_CRF)  ? body_i[20:18] : '0;
  assign imm_o     = (fmt_i == FMT_IMM)  ? body_i[15:12] : '0;
  assign mask_o    = (fmt_i == FMT_MASK) ? body_i[24:17] : '0;
  assign bit_o     = (fmt_i == FMT_BIT)  ? body_i[25:21] : '0;
endmodule

// File: rtl/fpdec_hold.sv
module fpdec_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/fpu_insn_decoder.sv
module fpu_insn_decoder
  import fpdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [OP_W-1:0]   op_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic              sp_o,
  output logic              update_o,
  output logic              zero_base_o,
  output logic              record_o,
  output logic [REG_W-1:0]  rt_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [REG_W-1:0]  rc_o,
  output logic [XLEN-1:0]   disp_o,
  output logic [CRF_W-1:0]  crf_dst_o,
  output logic [CRF_W-1:0]  crf_src_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [REG_W-1:0]  bit_o
);
  typedef struct packed {
    logic              ill;
    logic [OP_W-1:0]   op;
    logic [FMT_W-1:0]  fmt;
    logic              sp;
    logic              upd;
    logic              zb;
    logic              rec;
    logic [REG_W-1:0]  rt;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [REG_W-1:0]  rc;
    logic [XLEN-1:0]   disp;
    logic [CRF_W-1:0]  cd;
    logic [CRF_W-1:0]  cs;
    logic [IMM_W-1:0]  imm;
    logic [MASK_W-1:0] mask;
    logic [REG_W-1:0]  bi;
  } bund_t;

  localparam int BUND_W = $bits(bund_t);

  op_e   cls_op;
  fmt_e  cls_fmt;
  logic  cls_sp, cls_upd, cls_legal;
  logic [REG_W-1:0]  f_rt, f_ra, f_rb, f_rc, f_bit;
  logic [XLEN-1:0]   f_disp;
  logic [CRF_W-1:0]  f_cd, f_cs;
  logic [IMM_W-1:0]  f_imm;
  logic [MASK_W-1:0] f_mask;
  bund_t bund_d, bund_s;
  logic [BUND_W-1:0] bund_q;

  fpdec_classify i_classify (
    .prim_i  (insn_i[31:26]),
    .base_i  (insn_i[20:16]),
    .xo_i    (insn_i[10:1]),
    .op_o    (cls_op),
    .fmt_o   (cls_fmt),
    .sp_o    (cls_sp),
    .upd_o   (cls_upd),
    .legal_o (cls_legal)
  );

  fpdec_fields #(.XLEN(XLEN)) i_fields (
    .body_i    (insn_i[25:0]),
    .fmt_i     (cls_fmt),
    .rt_o      (f_rt),
    .ra_o      (f_ra),
    .rb_o      (f_rb),
    .rc_o      (f_rc),
    .disp_o    (f_disp),
    .crf_dst_o (f_cd),
    .crf_src_o (f_cs),
    .imm_o     (f_imm),
    .mask_o    (f_mask),
    .bit_o     (f_bit)
  );

  always_comb begin
    bund_d = '0;
    if (cls_legal) begin
      bund_d.op   = cls_op;
      bund_d.fmt  = cls_fmt;
      bund_d.sp   = cls_sp;
      bund_d.upd  = cls_upd;
      bund_d.zb   = (cls_fmt inside {FMT_DISP, FMT_IDX}) && (insn_i[20:16] == '0);
      bund_d.rec  = insn_i[0];
      bund_d.rt   = f_rt;
      bund_d.ra   = f_ra;
      bund_d.rb   = f_rb;
      bund_d.rc   = f_rc;
      bund_d.disp = f_disp;
      bund_d.cd   = f_cd;
      bund_d.cs   = f_cs;
      bund_d.imm  = f_imm;
      bund_d.mask = f_mask;
      bund_d.bi   = f_bit;
    end
    bund_d.ill = !cls_legal;
  end

  fpdec_hold #(.W(BUND_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .d_i    (bund_d),
    .q_o    (bund_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign bund_s      = bund_t'(bund_q);
  assign illegal_o   = bund_s.ill;
  assign op_o        = bund_s.op;
  assign fmt_o       = bund_s.fmt;
  assign sp_o        = bund_s.sp;
  assign update_o    = bund_s.upd;
  assign zero_base_o = bund_s.zb;
  assign record_o    = bund_s.rec;
  assign rt_o        = bund_s.rt;
  assign ra_o        = bund_s.ra;
  assign rb_o        = bund_s.rb;
  assign rc_o        = bund_s.rc;
  assign disp_o      = bund_s.disp;
  assign crf_dst_o   = bund_s.cd;
  assign crf_src_o   = bund_s.cs;
  assign imm_o       = bund_s.imm;
  assign mask_o      = bund_s.mask;
  assign bit_o       = bund_s.bi;
endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker
  import fpdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [INSN_W-1:0] insn_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [OP_W-1:0]   op_o,
  input logic [FMT_W-1:0]  fmt_o,
  input logic              sp_o,
  input logic              update_o,
  input logic              zero_base_o,
  input logic              record_o,
  input logic [REG_W-1:0]  rt_o,
  input logic [REG_W-1:0]  ra_o,
  input logic [REG_W-1:0]  rb_o,
  input logic [REG_W-1:0]  rc_o,
  input logic [XLEN-1:0]   disp_o,
  input logic [CRF_W-1:0]  crf_dst_o,
  input logic [CRF_W-1:0]  crf_src_o,
  input logic [IMM_W-1:0]  imm_o,
  input logic [MASK_W-1:0] mask_o,
  input logic [REG_W-1:0]  bit_o
);
  localparam int SIGN_N = XLEN - DISP_W + 1;

  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(op_o) && $stable(fmt_o) && $stable(illegal_o)); // R1

  AST_LEGAL_CLASSIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o |-> op_o != '0 && fmt_o != '0); // R2

  AST_SP_ONLY_59: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:26] != 6'd59 |=> !sp_o); // R4

  AST_BAD_PRIMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:29] != 3'b110 && !(insn_i[31:26] inside {6'd31, 6'd59, 6'd63})
    |=> illegal_o); // R7

  AST_DISP_UPD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:29] == 3'b110 && insn_i[26] && insn_i[20:16] == 5'd0
    |=> illegal_o); // R8

  AST_DISP_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fmt_o == FMT_DISP
    |-> ($countones(disp_o[XLEN-1:DISP_W-1]) == 0 || $countones(disp_o[XLEN-1:DISP_W-1]) == SIGN_N)); // R10

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> op_o == '0 && fmt_o == '0 && !sp_o && !update_o && !zero_base_o
      && !record_o && rt_o == '0 && ra_o == '0 && rb_o == '0 && rc_o == '0 && disp_o == '0
      && crf_dst_o == '0 && crf_src_o == '0 && imm_o == '0 && mask_o == '0 && bit_o == '0); // R14
endmodule

bind fpu_insn_decoder fpdec_checker #(.XLEN(XLEN)) i_fpdec_checker (.*);

// File: tb/test_fpu_insn_decoder.sv
module test_fpu_insn_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic valid_o, illegal_o, sp_o, update_o, zero_base_o, record_o;
  logic [5:0] op_o;
  logic [3:0] fmt_o;
  logic [4:0] rt_o, ra_o, rb_o, rc_o, bit_o;
  logic [XLEN-1:0] disp_o;
  logic [2:0] crf_dst_o, crf_src_o;
  logic [3:0] imm_o;
  logic [7:0] mask_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_insn_decoder #(.XLEN(XLEN)) i_fpu_insn_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .op_o(op_o), .fmt_o(fmt_o),
    .sp_o(sp_o), .update_o(update_o), .zero_base_o(zero_base_o), .record_o(record_o),
    .rt_o(rt_o), .ra_o(ra_o), .rb_o(rb_o), .rc_o(rc_o), .disp_o(disp_o),
    .crf_dst_o(crf_dst_o), .crf_src_o(crf_src_o), .imm_o(imm_o), .mask_o(mask_o),
    .bit_o(bit_o)
  );

  typedef struct {
    int ill, op, fmt, sp, upd, zb, rec, rt, ra, rb, rc, cd, cs, imm, mask, bi;
    logic [31:0] disp;
  } exp_t;

  exp_t held;

  function automatic int arith_op(int x, bit dbl);
    case (x)
      18: return 6;   20: return 7;   21: return 8;   22: return 9;
      23: return dbl ? 17 : 0;
      24: return 10;  25: return 11;  26: return 12;  28: return 13;
      29: return 14;  30: return 15;  31: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] w);
    exp_t e = '{default: 0};
    exp_t z = '{default: 0};
    int p = int'(w[31:26]);
    int x10 = int'(w[10:1]);
    int a = int'(w[20:16]);
    bit ok = 1;
    if (p >= 48 && p <= 55) begin
      e.op = 1 + (p - 48) / 2;
      e.fmt = 1;
      e.upd = p % 2;
      if (e.upd == 1 && a == 0) ok = 0;
    end else if (p == 31) begin
      e.fmt = 2;
      if (x10 == 983) e.op = 5;
      else if (x10 >= 535 && x10 <= 759 && (x10 - 535) % 32 == 0) begin
        int k = (x10 - 535) / 32;
        e.op = 1 + k / 2;
        e.upd = k % 2;
      end
      if (e.op != 0 && e.upd == 0 && a == 0 && e.op != 5) ok = 0;
    end else if (p == 59 || (p == 63 && w[5])) begin
      e.op = arith_op(int'(w[5:1]), p == 63);
      e.sp = (p == 59);
      if (e.op == 6 || e.op == 7 || e.op == 8) e.fmt = 3;
      else if (e.op == 11) e.fmt = 4;
      else if (e.op == 9 || e.op == 10 || e.op == 12) e.fmt = 6;
      else if (e.op >= 13) e.fmt = 5;
    end else if (p == 63) begin
      case (x10)
        0:   begin e.op = 18; e.fmt = 7;  end
        12:  begin e.op = 19; e.fmt = 6;  end
        14:  begin e.op = 20; e.fmt = 6;  end
        15:  begin e.op = 21; e.fmt = 6;  end
        32:  begin e.op = 22; e.fmt = 7;  end
        38:  begin e.op = 23; e.fmt = 9;  end
        40:  begin e.op = 24; e.fmt = 6;  end
        64:  begin e.op = 25; e.fmt = 8;  end
        70:  begin e.op = 26; e.fmt = 9;  end
        72:  begin e.op = 27; e.fmt = 6;  end
        134: begin e.op = 28; e.fmt = 10; end
        136: begin e.op = 29; e.fmt = 6;  end
        264: begin e.op = 30; e.fmt = 6;  end
        583: begin e.op = 31; e.fmt = 12; end
        711: begin e.op = 32; e.fmt = 11; end
        default: ;
      endcase
    end
    if (e.op == 0) ok = 0;
    if (!ok) begin
      z.ill = 1;
      return z;
    end
    e.rec = w[0];
    e.zb = (e.fmt == 1 || e.fmt == 2) && a == 0;
    if (e.fmt inside {1, 2, 3, 4, 5, 6, 12}) e.rt = int'(w[25:21]);
    if (e.fmt inside {1, 2, 3, 4, 5, 7})     e.ra = a;
    if (e.fmt inside {2, 3, 5, 6, 7, 11})    e.rb = int'(w[15:11]);
    if (e.fmt inside {4, 5})                 e.rc = int'(w[10:6]);
    if (e.fmt == 1) e.disp = {{16{w[15]}}, w[15:0]};
    if (e.fmt inside {7, 8, 10}) e.cd = int'(w[25:23]);
    if (e.fmt == 8)  e.cs = int'(w[20:18]);
    if (e.fmt == 10) e.imm = int'(w[15:12]);
    if (e.fmt == 11) e.mask = int'(w[24:17]);
    if (e.fmt == 9)  e.bi = int'(w[25:21]);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input int ev);
    chk("R1 valid_o", 64'(valid_o), 64'(ev));
    chk("R7 illegal_o", 64'(illegal_o), 64'(held.ill));
    chk("R2 op_o", 64'(op_o), 64'(held.op));
    chk("R2 fmt_o", 64'(fmt_o), 64'(held.fmt));
    chk("R4 sp_o", 64'(sp_o), 64'(held.sp));
    chk("R12 update_o", 64'(update_o), 64'(held.upd));
    chk("R8 zero_base_o", 64'(zero_base_o), 64'(held.zb));
    chk("R13 record_o", 64'(record_o), 64'(held.rec));
    chk("R9 regs", {44'd0, rt_o, ra_o, rb_o, rc_o},
        {44'd0, 5'(held.rt), 5'(held.ra), 5'(held.rb), 5'(held.rc)});
    chk("R10 disp_o", 64'(disp_o), 64'(held.disp));
    chk("R11 ctrl", {38'd0, crf_dst_o, crf_src_o, imm_o, mask_o, bit_o},
        {38'd0, 3'(held.cd), 3'(held.cs), 4'(held.imm), 8'(held.mask), 5'(held.bi)});
  endtask

  // called at a falling edge; result compared at the next falling edge
  task automatic step(input logic [31:0] w, input bit v);
    insn_i = w;
    valid_i = v;
    if (v) held = model(w);
    @(negedge clk);
    compare_all(int'(v));
  endtask

  function automatic logic [31:0] wx(int p, int t, int a, int b, int xo, bit rc = 0);
    return {p[5:0], t[4:0], a[4:0], b[4:0], xo[9:0], rc};
  endfunction

  function automatic logic [31:0] wa(int p, int t, int a, int b, int c, int xo, bit rc = 0);
    return {p[5:0], t[4:0], a[4:0], b[4:0], c[4:0], xo[4:0], rc};
  endfunction

  function automatic logic [31:0] wd(int p, int t, int a, logic [15:0] d);
    return {p[5:0], t[4:0], a[4:0], d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    held = '{default: 0};
    repeat (3) @(negedge clk);
    chk("R1 reset valid_o", 64'(valid_o), 64'd0);
    chk("R1 reset op_o", 64'(op_o), 64'd0);
    chk("R1 reset disp_o", 64'(disp_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    step(wd(51, 7, 0, 16'h0010), 1);
    chk("R8 disp update base 0 illegal", 64'(illegal_o), 64'd1);
    chk("R14 illegal op zero", 64'(op_o), 64'd0);
    step(wd(51, 7, 3, 16'h8000), 1);
    chk("R12 disp update", 64'(update_o), 64'd1);
    chk("R10 negative disp", 64'(disp_o), 64'hFFFF8000);
    chk("R2 load-double", 64'(op_o), 64'd2);
    step(wd(48, 2, 0, 16'h7FFF), 1);
    chk("R8 disp base 0 zero base", 64'(zero_base_o), 64'd1);
    chk("R10 positive disp", 64'(disp_o), 64'h00007FFF);
    step(wx(31, 4, 0, 9, 983), 1);
    chk("R3 store-integer-word", 64'(op_o), 64'd5);
    chk("R8 store-integer-word base 0 legal", 64'(illegal_o), 64'd0);
    chk("R3 indexed B", 64'(rb_o), 64'd9);
    step(wx(31, 4, 0, 9, 535), 1);
    chk("R8 indexed base 0 illegal", 64'(illegal_o), 64'd1);
    step(wx(31, 4, 0, 9, 567), 1);
    chk("R8 indexed update base 0 legal", 64'(illegal_o), 64'd0);
    chk("R12 indexed update", 64'(update_o), 64'd1);
    step(wx(31, 4, 6, 9, 2), 1);
    chk("R3 unknown extended illegal", 64'(illegal_o), 64'd1);
    step(wa(59, 1, 2, 3, 4, 23), 1);
    chk("R4 select absent in single", 64'(illegal_o), 64'd1);
    step(wa(59, 1, 2, 3, 4, 25), 1);
    chk("R4 single multiply", {56'd0, op_o, sp_o, 1'b0}, {56'd0, 6'd11, 1'b1, 1'b0});
    chk("R9 multiply uses C not B", {54'd0, rb_o, rc_o}, {54'd0, 5'd0, 5'd4});
    step(wa(63, 1, 2, 3, 4, 23), 1);
    chk("R5 select", {54'd0, op_o, fmt_o}, {54'd0, 6'd17, 4'd5});
    chk("R5 double sp clear", 64'(sp_o), 64'd0);
    step(wa(63, 1, 2, 3, 4, 19), 1);
    chk("R5 unmatched 5-bit illegal", 64'(illegal_o), 64'd1);
    step(wx(63, 23, 11, 19, 134), 1);
    chk("R6 set field immediate", 64'(op_o), 64'd28);
    chk("R11 immediate fields", {57'd0, crf_dst_o, imm_o}, {57'd0, 3'd5, 4'd9});
    step({6'd63, 1'b0, 8'hA5, 1'b0, 5'd6, 10'd711, 1'b0}, 1);
    chk("R11 mask", 64'(mask_o), 64'hA5);
    chk("R9 mask uses B", 64'(rb_o), 64'd6);
    step(wx(63, 24, 12, 0, 64), 1);
    chk("R11 move status field", {58'd0, crf_dst_o, crf_src_o}, {58'd0, 3'd6, 3'd3});
    step(wx(63, 13, 0, 0, 38), 1);
    chk("R11 set bit number", {54'd0, op_o, bit_o[3:0]}, {54'd0, 6'd23, 4'd13});
    step(wx(63, 20, 1, 2, 0, 1), 1);
    chk("R13 record flag", 64'(record_o), 64'd1);
    chk("R6 unordered compare", 64'(crf_dst_o), 64'd5);
    step(wx(63, 9, 0, 0, 583), 1);
    chk("R6 read status", {54'd0, op_o, fmt_o}, {54'd0, 6'd31, 4'd12});
    step(32'h03FF_FFFF, 1);
    chk("R7 bad primary illegal", 64'(illegal_o), 64'd1);
    chk("R14 illegal valid", 64'(valid_o), 64'd1);
    chk("R14 illegal record zero", 64'(record_o), 64'd0);
    step(wx(63, 1, 0, 2, 72), 1);
    step(32'hFFFF_FFFF, 0);
    chk("R1 idle no valid", 64'(valid_o), 64'd0);
    chk("R1 idle hold op", 64'(op_o), 64'd27);

    for (int i = 0; i < 800; i++) begin
      logic [31:0] w = $urandom;
      int sel = $urandom_range(0, 9);
      int xo10_31 [9] = '{535, 567, 599, 631, 663, 695, 727, 759, 983};
      int xo10_63 [15] = '{0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711};
      if (sel < 2) w[31:26] = 6'(48 + $urandom_range(0, 7));
      else if (sel < 4) begin
        w[31:26] = 6'd31;
        if ($urandom_range(0, 3) != 0) w[10:1] = 10'(xo10_31[$urandom_range(0, 8)]);
      end else if (sel < 6) w[31:26] = 6'd59;
      else if (sel < 8) begin
        w[31:26] = 6'd63;
        if ($urandom_range(0, 2) == 0) w[10:1] = 10'(xo10_63[$urandom_range(0, 14)]);
      end
      if ($urandom_range(0, 3) == 0) w[20:16] = 5'd0;
      step(w, $urandom_range(0, 4) != 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule